// File: doc/BRIEF.md
# Memory-Test Pseudo-Random Data Generator

This block supplies test data for a wide memory port. A 31-bit linear feedback shift register runs the polynomial x^31 + x^28 + 1. On every clock with the advance strobe high it moves forward by `STEP_BITS` serial steps. The newest `STEP_BITS` bits of the register are repeated end to end to fill a data word `PORT_W` bits wide. Taken one after another, the words reproduce the serial pseudo-random bit stream without gaps.

The data word is a combinational function of the register state, not a registered copy. The word that follows a reset or a seed load therefore already carries pattern data. A write path and a later read-back path can each own one instance. Both are loaded with the same seed and advanced once per transferred word, so they stay in lockstep. A seed of zero would lock the register, so the block replaces it with a fixed non-zero default.

Top module: `prbs_mem_datagen`

## Requirements
- R1: While `rst` is high at a clock edge, the state loads `DEFAULT_SEED`. Right after reset, `data_o` holds the low `STEP_BITS` bits of that seed repeated, and the default seed makes this word non-zero.
- R2: `data_o` follows the state within the same cycle, with no extra register stage. The first word after a load or reset is valid at once.
- R3: When `adv_i` is high and `seed_load_i` is low at an edge, the state takes `STEP_BITS` serial steps. Each serial step computes fb = s[30] XOR s[27], then sets s = {s[29:0], fb}.
- R4: Bits [STEP_BITS-1:0] of `data_o` equal state bits [STEP_BITS-1:0]. Bit 0 is the most recently generated bit.
- R5: For every j below `PORT_W`, bit j of `data_o` equals bit (j mod `STEP_BITS`), including a trailing partial copy.
- R6: When both `adv_i` and `seed_load_i` are low, the state and `data_o` do not change.
- R7: When `seed_load_i` is high and `seed_i` is non-zero, the state becomes `seed_i`. A seed load takes priority over `adv_i`.
- R8: When `seed_load_i` is high and `seed_i` is zero, the state becomes `DEFAULT_SEED`.
- R9: The state is never all zeros.
- R10: Elaboration rejects any of these parameter settings: `STEP_BITS` outside 1..30, `STEP_BITS` above `PORT_W` or `ADDR_W`, or a `DEFAULT_SEED` whose low `STEP_BITS` bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the default seed |
| seed_load_i | input | 1 | Load `seed_i` into the state (zero selects the default) |
| seed_i | input | 31 | Seed value |
| adv_i | input | 1 | Advance the state by `STEP_BITS` bits |
| data_o | output | PORT_W | Replicated pattern word |

## Verification
The bench builds the block with `STEP_BITS` = 8 and `PORT_W` = 60. Because 60 is not a multiple of 8, the last copy in the word is cut to four bits, which exercises the partial-copy case of the fill logic. The small step also lets a long run of advances cross the point where early register bits reach the feedback taps. Zero seeds, non-zero seeds, load-over-advance priority and idle cycles are mixed into the run.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
   localparam int unsigned LFSR_W = 31;
   localparam int unsigned TAP_HI = 30;
   localparam int unsigned TAP_LO = 27;

   typedef logic [LFSR_W-1:0] lfsr_state_t;

   // Unrolled serial recurrence: n single-bit steps in one combinational pass.
   function automatic lfsr_state_t lfsr_advance(input lfsr_state_t s, input int unsigned n);
      lfsr_state_t r;
      logic        fb;
      r = s;
      for (int unsigned i = 0; i < n; i++) begin
         fb = r[TAP_HI] ^ r[TAP_LO];
         r  = {r[LFSR_W-2:0], fb};
      end
      return r;
   endfunction
endpackage

// File: rtl/prbs_multistep_lfsr.sv
module prbs_multistep_lfsr
   import prbs_gen_pkg::*;
#(
   parameter int unsigned STEP_BITS    = 16,
   parameter lfsr_state_t DEFAULT_SEED = 31'h5A5A_1234
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        seed_load_i,
   input  lfsr_state_t seed_i,
   input  logic        adv_i,
   output lfsr_state_t state_o
);
   lfsr_state_t state_q;
   lfsr_state_t state_d;
   lfsr_state_t stepped;
   lfsr_state_t seed_eff;

   assign stepped  = lfsr_advance(state_q, STEP_BITS);
   assign seed_eff = (seed_i == '0) ? DEFAULT_SEED : seed_i;

   always_comb begin
      state_d = state_q;
      if (seed_load_i)  state_d = seed_eff;
      else if (adv_i)   state_d = stepped;
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= DEFAULT_SEED;
      else     state_q <= state_d;
   end

   assign state_o = state_q;

   AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
      state_q != '0); // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!adv_i && !seed_load_i) |=> $stable(state_q)); // R6
   AST_ADVANCE_SHIFTS: assert property (@(posedge clk) disable iff (rst)
      (adv_i && !seed_load_i) |=> state_q[LFSR_W-1:STEP_BITS] == $past(state_q[LFSR_W-1-STEP_BITS:0])); // R3
   AST_SEED_LOADS: assert property (@(posedge clk) disable iff (rst)
      (seed_load_i && seed_i != '0) |=> state_q == $past(seed_i)); // R7
   AST_ZERO_SEED_SUBST: assert property (@(posedge clk) disable iff (rst)
      (seed_load_i && seed_i == '0) |=> state_q == DEFAULT_SEED); // R8
endmodule

// File: rtl/prbs_word_fill.sv
module prbs_word_fill #(
   parameter int unsigned STEP_BITS = 16,
   parameter int unsigned PORT_W    = 128
) (
   input  logic [STEP_BITS-1:0] chunk_i,
   output logic [PORT_W-1:0]    word_o
);
   localparam int unsigned FULL_COPIES = PORT_W / STEP_BITS;
   localparam int unsigned TAIL_BITS   = PORT_W % STEP_BITS;

   generate
      for (genvar k = 0; k < FULL_COPIES; k++) begin : g_copy
         assign word_o[k*STEP_BITS +: STEP_BITS] = chunk_i;
      end
      if (TAIL_BITS != 0) begin : g_tail
         assign word_o[PORT_W-1 -: TAIL_BITS] = chunk_i[TAIL_BITS-1:0];
      end
   endgenerate
endmodule

// File: rtl/prbs_mem_datagen.sv
module prbs_mem_datagen
   import prbs_gen_pkg::*;
#(
   parameter int unsigned STEP_BITS    = 16,
   parameter int unsigned PORT_W       = 128,
   parameter int unsigned ADDR_W       = 32,
   parameter lfsr_state_t DEFAULT_SEED = 31'h5A5A_1234
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              seed_load_i,
   input  logic [30:0]       seed_i,
   input  logic              adv_i,
   output logic [PORT_W-1:0] data_o
);
   // R10: elaboration-time parameter checks
   generate
      if (STEP_BITS < 1 || STEP_BITS >= LFSR_W) begin : g_bad_step
         $error("STEP_BITS must lie in 1..30");
      end
      if (STEP_BITS > PORT_W || STEP_BITS > ADDR_W) begin : g_bad_width
         $error("STEP_BITS exceeds port data width or address width");
      end
      if (DEFAULT_SEED[STEP_BITS-1:0] == '0) begin : g_bad_seed
         $error("DEFAULT_SEED must give a non-zero first word");
      end
   endgenerate

   lfsr_state_t state;

   prbs_multistep_lfsr #(
      .STEP_BITS    (STEP_BITS),
      .DEFAULT_SEED (DEFAULT_SEED)
   ) u_lfsr (
      .clk         (clk),
      .rst         (rst),
      .seed_load_i (seed_load_i),
      .seed_i      (seed_i),
      .adv_i       (adv_i),
      .state_o     (state)
   );

   prbs_word_fill #(
      .STEP_BITS (STEP_BITS),
      .PORT_W    (PORT_W)
   ) u_fill (
      .chunk_i (state[STEP_BITS-1:0]),
      .word_o  (data_o)
   );

   AST_WORD_NONZERO_AFTER_RESET: assert property (@(posedge clk)
      $fell(rst) |-> data_o != '0); // R1
endmodule

// File: tb/prbs_mem_datagen_tb.sv
module prbs_mem_datagen_tb;
   localparam int unsigned STEP   = 8;
   localparam int unsigned PW     = 60;
   localparam logic [30:0] DSEED  = 31'h5A5A_1234;
   localparam time         CLK_PERIOD = 10ns;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          seed_load = 1'b0;
   logic [30:0]   seed = '0;
   logic          adv = 1'b0;
   logic [PW-1:0] data;

   int checks = 0;
   int fails  = 0;
   logic [30:0] model;
   logic [PW-1:0] exp_q[$];
   string         tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   prbs_mem_datagen #(.STEP_BITS(STEP), .PORT_W(PW), .ADDR_W(32), .DEFAULT_SEED(DSEED)) u_dut (
      .clk(clk), .rst(rst), .seed_load_i(seed_load), .seed_i(seed),
      .adv_i(adv), .data_o(data));

   function automatic logic [30:0] serial_step(input logic [30:0] s);
      logic [30:0] r;
      r = s;
      for (int i = 0; i < int'(STEP); i++) r = {r[29:0], r[30] ^ r[27]};
      return r;
   endfunction

   function automatic logic [PW-1:0] expand(input logic [30:0] s);
      logic [PW-1:0] w;
      for (int j = 0; j < int'(PW); j++) w[j] = s[j % STEP];
      return w;
   endfunction

   // Driver: apply stimulus at negedge, push expected word after the edge.
   task automatic drive(input logic a, input logic l, input logic [30:0] sv, input string tag);
      @(negedge clk);
      adv = a; seed_load = l; seed = sv;
      if (l)      model = (sv == '0) ? DSEED : sv;
      else if (a) model = serial_step(model);
      @(posedge clk); #1;
      exp_q.push_back(expand(model));
      tag_q.push_back(tag);
   endtask

   // Monitor: compare at negedge.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [PW-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (data !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, data, e);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      model = DSEED;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R1 / R2: word valid and non-zero immediately after reset
      checks++;
      if (data !== expand(DSEED) || data == '0) begin
         fails++;
         $display("FAIL R1 reset word actual=%h expected=%h", data, expand(DSEED));
      end
      // R3 R4 R5: run of advances
      for (int i = 0; i < 200; i++) drive(1'b1, 1'b0, '0, "R3 advance");
      // R6: idle holds
      for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, '0, "R6 idle hold");
      // R7: seed load and priority over advance
      drive(1'b0, 1'b1, 31'h0000_0081, "R7 seed load");
      drive(1'b1, 1'b1, 31'h1357_9BDF, "R7 load beats advance");
      for (int i = 0; i < 50; i++) drive(1'b1, 1'b0, '0, "R2 advance after load");
      // R8: zero seed replaced by default
      drive(1'b1, 1'b1, '0, "R8 zero seed");
      // mixed pattern
      for (int i = 0; i < 400; i++) drive(i % 3 != 0, 1'b0, '0, "R5 mixed advance");
      // reset mid-stream reloads default
      @(negedge clk); adv = 1'b1; rst = 1'b1;
      @(negedge clk); rst = 1'b0; adv = 1'b0; model = DSEED;
      checks++;
      if (data !== expand(DSEED)) begin
         fails++;
         $display("FAIL R1 re-reset actual=%h expected=%h", data, expand(DSEED));
      end
      // R9: state keeps producing; long run should never make a zero word stick
      for (int i = 0; i < 300; i++) drive(1'b1, 1'b0, '0, "R9 long run");
      @(negedge clk); @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule